// File: doc/BRIEF.md
# Serial Weighted Spike Accumulator

This block forms the synaptic input of one neuron in a spiking network. It looks at a set of predecessor neurons, one per clock, through a single shared selector. Each predecessor provides a one-bit spike flag and a signed connection weight. The selector passes on the flag and the weight of the predecessor chosen by the current index. A gate turns that pair into a contribution: the weight if the flag is set, zero if it is not. A second selector then chooses what the temporary sum register takes: a cleared value, the running sum plus the contribution, or its own value.

A `start_i` pulse in the idle state clears the sum and the index and begins a scan. The scan takes exactly `N_SRC` cycles. After it a one-cycle `done_o` pulse marks the total on `sum_o` as valid. The total then holds until the next accepted start.

The control state machine has three states. `ST_IDLE` waits, and on `start_i` takes the transition *go* to `ST_SCAN`. `ST_SCAN` adds one predecessor per cycle. It stays in `ST_SCAN` while the index is below the last one (*step*). After adding the last index it takes *last_step* to `ST_DONE`. `ST_DONE` asserts `done_o` for one cycle and returns to `ST_IDLE` through *retire*.

Top module: `spike_accum_top`

## Requirements
- R1: After reset, `sum_o` is 0 and `done_o` is 0.
- R2: Bit k of `spk_vec_i` is the spike flag of predecessor k, and bits [16k+15:16k] of `wgt_vec_i` hold its weight. The weight is added only when the flag is 1; a predecessor whose flag is 0 adds zero, whatever its weight is.
- R3: Weights are signed 16-bit two's-complement values. The total is the exact signed sum over `N_SRC` predecessors, with no overflow even when every weight is -32768 or every weight is 32767.
- R4: An accepted start clears the sum, so `sum_o` is 0 in the cycle after the start edge. Each total depends only on the inputs of its own scan.
- R5: A start is accepted on a clock edge in `ST_IDLE`. `done_o` rises in the cycle that follows the `N_SRC`-th clock edge after that start edge, and it is 0 in every cycle before.
- R6: `done_o` is high for exactly one cycle per scan.
- R7: After `done_o`, `sum_o` keeps its value until the next accepted start, even if the spike and weight inputs change.
- R8: A `start_i` pulse during a scan or in `ST_DONE` is ignored. The scan goes on without restarting, and it gives the same total and the same `done_o` timing as a scan without that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a scan |
| spk_vec_i | input | N_SRC | Spike flag per predecessor |
| wgt_vec_i | input | 16·N_SRC | Packed signed weights, predecessor k at bits [16k+15:16k] |
| sum_o | output | 16+clog2(N_SRC) | Signed accumulated input |
| done_o | output | 1 | One-cycle pulse: the total is valid |

## Verification
The checker assumes that `start_i` is a synchronous level sampled at the rising edge. It also assumes that the spike and weight inputs stay unchanged from the start edge until `done_o`, because the total is defined only over a steady input set. The bench drives every input on the falling edge. It holds flags and weights fixed for the whole scan and changes them only after `done_o`, which is also how it shows that the held total ignores such changes. The one start that arrives mid-scan is driven while the flags and weights are steady, so the total it is compared against stays well defined.

// File: rtl/spike_accum_pkg.sv
package spike_accum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } acc_state_t;

    typedef enum logic [1:0] {
        TMP_HOLD  = 2'd0,
        TMP_CLEAR = 2'd1,
        TMP_ADD   = 2'd2
    } tmp_sel_t;

endpackage

// File: rtl/src_select.sv
module src_select #(
    parameter int N_SRC   = 8,
    parameter int W_WIDTH = 16,
    parameter int IDX_W   = 3
) (
    input  logic [IDX_W-1:0]         idx_i,
    input  logic [N_SRC-1:0]         spk_vec_i,
    input  logic [N_SRC*W_WIDTH-1:0] wgt_vec_i,
    output logic                     sel_spk_o,
    output logic [W_WIDTH-1:0]       sel_wgt_o
);
    logic [W_WIDTH-1:0] wgt_arr [N_SRC];

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_unpack
            assign wgt_arr[g] = wgt_vec_i[g*W_WIDTH +: W_WIDTH];
        end
    endgenerate

    always_comb begin
        sel_spk_o = 1'b0;
        sel_wgt_o = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (idx_i == IDX_W'(k)) begin
                sel_spk_o = spk_vec_i[k];
                sel_wgt_o = wgt_arr[k];
            end
        end
    end
endmodule

// File: rtl/contrib_gate.sv
module contrib_gate #(
    parameter int W_WIDTH = 16,
    parameter int SUM_W   = 19
) (
    input  logic                    spk_i,
    input  logic [W_WIDTH-1:0]      wgt_i,
    output logic signed [SUM_W-1:0] contrib_o
);
    logic signed [W_WIDTH-1:0] wgt_s;
    assign wgt_s = $signed(wgt_i);

    always_comb begin
        if (spk_i) contrib_o = SUM_W'(wgt_s);
        else       contrib_o = '0;
    end
endmodule

// File: rtl/tmp_reg.sv
module tmp_reg
    import spike_accum_pkg::*;
#(
    parameter int SUM_W = 19
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  tmp_sel_t                sel_i,
    input  logic signed [SUM_W-1:0] contrib_i,
    output logic signed [SUM_W-1:0] q_o
);
    logic signed [SUM_W-1:0] d;

    always_comb begin
        unique case (sel_i)
            TMP_CLEAR: d = '0;
            TMP_ADD:   d = q_o + contrib_i;
            default:   d = q_o;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d;
    end
endmodule

// File: rtl/spike_accum_top.sv
module spike_accum_top
    import spike_accum_pkg::*;
#(
    parameter int N_SRC   = 8,
    parameter int W_WIDTH = 16,
    localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int SUM_W  = W_WIDTH + IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [N_SRC-1:0]         spk_vec_i,
    input  logic [N_SRC*W_WIDTH-1:0] wgt_vec_i,
    output logic [SUM_W-1:0]         sum_o,
    output logic                     done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SRC - 1);

    acc_state_t              state, state_nxt;
    logic [IDX_W-1:0]        idx;
    tmp_sel_t                tmp_sel;
    logic                    sel_spk;
    logic [W_WIDTH-1:0]      sel_wgt;
    logic signed [SUM_W-1:0] contrib;
    logic signed [SUM_W-1:0] acc_q;
    logic                    at_last;

    assign at_last = (idx == LAST_IDX);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start_i) state_nxt = ST_SCAN;
            ST_SCAN: if (at_last) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && start_i) idx <= '0;
            else if (state == ST_SCAN && !at_last) idx <= idx + 1'b1;
        end
    end

    always_comb begin
        tmp_sel = TMP_HOLD;
        done_o  = 1'b0;
        unique case (state)
            ST_IDLE: if (start_i) tmp_sel = TMP_CLEAR;
            ST_SCAN: tmp_sel = TMP_ADD;
            ST_DONE: done_o = 1'b1;
            default: tmp_sel = TMP_HOLD;
        endcase
    end

    src_select #(.N_SRC(N_SRC), .W_WIDTH(W_WIDTH), .IDX_W(IDX_W)) u_sel (
        .idx_i(idx), .spk_vec_i(spk_vec_i), .wgt_vec_i(wgt_vec_i),
        .sel_spk_o(sel_spk), .sel_wgt_o(sel_wgt)
    );

    contrib_gate #(.W_WIDTH(W_WIDTH), .SUM_W(SUM_W)) u_gate (
        .spk_i(sel_spk), .wgt_i(sel_wgt), .contrib_o(contrib)
    );

    tmp_reg #(.SUM_W(SUM_W)) u_tmp (
        .clk(clk), .rst_n(rst_n), .sel_i(tmp_sel),
        .contrib_i(contrib), .q_o(acc_q)
    );

    assign sum_o = acc_q;
endmodule

// File: rtl/spike_accum_chk.sv
module spike_accum_chk #(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3,
    parameter int SUM_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic [SUM_W-1:0] sum_o,
    input logic [1:0]       state,
    input logic [IDX_W-1:0] idx
);
    localparam int CW = IDX_W + 2;
    logic [CW-1:0] cyc;
    logic          accept;
    assign accept = (state == 2'd0) && start_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cyc <= '1;
        else if (accept)               cyc <= '0;
        else if (cyc != {CW{1'b1}})    cyc <= cyc + 1'b1;
    end

    // R4
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (sum_o == '0));

    // R5
    scan_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc == CW'(N_SRC)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(sum_o));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && idx != IDX_W'(N_SRC - 1)) |=> (idx == $past(idx) + 1'b1));
endmodule

bind spike_accum_top spike_accum_chk #(
    .N_SRC(N_SRC), .IDX_W(IDX_W), .SUM_W(SUM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .sum_o(sum_o), .state(state), .idx(idx)
);

// File: tb/sim_spike_accum_top.sv
`timescale 1ns/1ps
module sim_spike_accum_top;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int SW = W + 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [N-1:0]    spk = '0;
    logic [N*W-1:0]  wgt = '0;
    logic [SW-1:0]   sum_o;
    logic            done_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spike_accum_top #(.N_SRC(N), .W_WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .spk_vec_i(spk),
        .wgt_vec_i(wgt), .sum_o(sum_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sum_of(input logic [N-1:0] s, input logic [N*W-1:0] w);
        int t = 0;
        for (int k = 0; k < N; k++)
            if (s[k]) t += int'($signed(w[k*W +: W]));
        return t;
    endfunction

    function automatic int sval(input logic [SW-1:0] v);
        return int'($signed(v));
    endfunction

    // Full scan; optional start pulse in the middle of the scan.
    task automatic run_scan(input string req, input logic [N-1:0] s,
                            input logic [N*W-1:0] w, input bit mid_start);
        int exp;
        int early;
        exp = sum_of(s, w);
        early = 0;
        @(negedge clk);
        spk = s; wgt = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R4 cleared"}, sval(sum_o), 0);
        for (int k = 0; k < N; k++) begin
            if (done_o) early++;
            start_i = (mid_start && k == 3);
            @(negedge clk);
        end
        start_i = 1'b0;
        check({req, " R5 no early done"}, early, 0);
        check({req, " R5 done"}, int'(done_o), 1);
        check({req, " total"}, sval(sum_o), exp);
        start_i = mid_start;
        spk = ~s; wgt = ~w;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R6 done low"}, int'(done_o), 0);
        check({req, " R7 hold"}, sval(sum_o), exp);
        @(negedge clk);
        check({req, " R7 hold2"}, sval(sum_o), exp);
    endtask

    task automatic t_reset();
        #1;
        check("R1 sum", sval(sum_o), 0);
        check("R1 done", int'(done_o), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sum after release", sval(sum_o), 0);
    endtask

    task automatic t_mixed();
        logic [N*W-1:0] w;
        for (int k = 0; k < N; k++) w[k*W +: W] = W'(100 * (k + 1) - 350);
        run_scan("R2 mixed", 8'b1010_0110, w, 1'b0);
    endtask

    task automatic t_none();
        logic [N*W-1:0] w;
        for (int k = 0; k < N; k++) w[k*W +: W] = 16'h7FFF;
        run_scan("R2 no spikes", 8'b0, w, 1'b0);
    endtask

    task automatic t_extremes();
        logic [N*W-1:0] w;
        for (int k = 0; k < N; k++) w[k*W +: W] = 16'h7FFF;
        run_scan("R3 all max", 8'hFF, w, 1'b0);
        for (int k = 0; k < N; k++) w[k*W +: W] = 16'h8000;
        run_scan("R3 all min", 8'hFF, w, 1'b0);
    endtask

    task automatic t_single_last();
        logic [N*W-1:0] w;
        w = '0;
        w[(N-1)*W +: W] = 16'hFFF6;
        w[0 +: W] = 16'd55;
        run_scan("R2 last only", 8'b1000_0000, w, 1'b0);
    endtask

    task automatic t_ignored_start();
        logic [N*W-1:0] w;
        for (int k = 0; k < N; k++) w[k*W +: W] = W'(37 * k - 90);
        run_scan("R8 mid start", 8'b0111_1011, w, 1'b1);
    endtask

    initial begin
        t_reset();
        t_mixed();
        t_none();
        t_extremes();
        t_single_last();
        t_ignored_start();
        t_mixed();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule